// File: doc/BRIEF.md
# Two-Tone Phase-Continuous Audio Modulator

This block turns a serial bit stream into 4-bit unsigned audio samples for a resistor-ladder DAC, as used by a 1200-baud packet modem. A single clock-derived sample timebase drives the block. A phase accumulator gains a tone-dependent increment on every sample tick, and the top four accumulator bits index a 16-entry sine table. Only one of two tones is active at a time: mark at 1200 Hz or space at 2200 Hz.

After a fixed number of sample ticks the block reaches a symbol boundary. There it raises a one-cycle request and takes the bit that the source presents in the same cycle. A 0 bit swaps the active tone. A 1 bit keeps the current tone, which is the NRZI rule. The accumulator is never reset on a tone swap, so the waveform changes frequency without a phase jump. When the enable is low, the output holds midscale and all internal state returns to its start values.

Top module: `nrzi_tone_synth`

## Requirements
- R1: During reset and after reset release, with enable low, `bit_req_o` is 0 and `sample_o` is 8.
- R2: While enabled, a sample tick happens every CLK_HZ/SAMPLE_HZ clocks, counted from the cycle enable rises. On each tick the ACC_W-bit accumulator adds floor(f·2^ACC_W/SAMPLE_HZ) modulo 2^ACC_W. Here f is MARK_HZ (1200) or SPACE_HZ (2200), whichever tone was active before that tick.
- R3: `bit_req_o` is high for exactly one cycle, on the last tick of every SAMPLE_HZ/BAUD_HZ ticks. It is never high on two consecutive cycles.
- R4: `bit_i` is sampled in the cycle where `bit_req_o` is high. A value of 0 swaps the active tone and a value of 1 keeps it. The new tone applies from the next tick onward.
- R5: After reset and after each enable, the active tone is mark (1200 Hz) and the accumulator is 0.
- R6: While enabled, `sample_o` equals T[acc[ACC_W-1:ACC_W-4]]. T is, for indices 0 to 15: 8,10,13,14,15,14,13,10,8,5,2,1,0,1,2,5.
- R7: A tone swap does not reset or jump the accumulator. The increment alone changes.
- R8: While `en_i` is low, `sample_o` is 8 in the same cycle and `bit_req_o` is 0. The accumulator, tick counters and tone return to their start values at the next clock edge.
- R9: `bit_i` has no effect on the tone or the samples in any cycle where `bit_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Modulator enable; low forces midscale and clears state |
| bit_i | input | 1 | Next data bit, taken while bit_req_o is high |
| bit_req_o | output | 1 | One-cycle request at each symbol boundary |
| sample_o | output | 4 | Unsigned sine sample for the ladder DAC |

## Verification
A wrong tone register shows up on `sample_o` from the next sample tick, because the table index begins advancing at the wrong rate. The bench's per-cycle comparison flags it within a few ticks. A skipped or extra accumulator step, or a reset of phase at a swap, changes the table index and so the sample at the next tick. A misplaced symbol boundary shifts `bit_req_o` against the reference, and the bench sees it in the first symbol period. Noise on `bit_i` outside request cycles would show up as a tone swap the reference does not make.

// File: rtl/nrzi_tone_pkg.sv
package nrzi_tone_pkg;

  typedef enum logic {
    TONE_MARK  = 1'b0,
    TONE_SPACE = 1'b1
  } tone_e;

  localparam logic [3:0] MIDSCALE = 4'd8;

  // 16-step sine, 4-bit unsigned, offset 7.5 amplitude 7.5
  function automatic logic [3:0] sine16(input logic [3:0] idx);
    logic [3:0] v;
    case (idx)
      4'd0:  v = 4'd8;
      4'd1:  v = 4'd10;
      4'd2:  v = 4'd13;
      4'd3:  v = 4'd14;
      4'd4:  v = 4'd15;
      4'd5:  v = 4'd14;
      4'd6:  v = 4'd13;
      4'd7:  v = 4'd10;
      4'd8:  v = 4'd8;
      4'd9:  v = 4'd5;
      4'd10: v = 4'd2;
      4'd11: v = 4'd1;
      4'd12: v = 4'd0;
      4'd13: v = 4'd1;
      4'd14: v = 4'd2;
      default: v = 4'd5;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tone_timebase.sv
module tone_timebase #(
  parameter int SAMPLE_DIV = 256,
  parameter int BAUD_DIV   = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic baud_o
);
  localparam int SD_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int BD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [SD_W-1:0] SD_LAST = SD_W'(SAMPLE_DIV - 1);
  localparam logic [BD_W-1:0] BD_LAST = BD_W'(BAUD_DIV - 1);

  generate
    if (SAMPLE_DIV > 1) begin : g_sdiv
      logic [SD_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          div_q <= '0;
        else if (!en_i)       div_q <= '0;
        else if (div_q == SD_LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
      end
      assign tick_o = en_i && (div_q == SD_LAST);
    end else begin : g_sdiv_bypass
      assign tick_o = en_i;
    end

    if (BAUD_DIV > 1) begin : g_bdiv
      logic [BD_W-1:0] sym_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sym_q <= '0;
        else if (!en_i)   sym_q <= '0;
        else if (tick_o)  sym_q <= (sym_q == BD_LAST) ? '0 : sym_q + 1'b1;
      end
      assign baud_o = tick_o && (sym_q == BD_LAST);
    end else begin : g_bdiv_bypass
      assign baud_o = tick_o;
    end
  endgenerate

endmodule

// File: rtl/nrzi_tone_select.sv
module nrzi_tone_select
  import nrzi_tone_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  baud_i,
  input  logic  bit_i,
  output tone_e tone_o
);
  tone_e tone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tone_q <= TONE_MARK;
    else if (!en_i)           tone_q <= TONE_MARK;
    else if (baud_i && !bit_i)
      tone_q <= (tone_q == TONE_MARK) ? TONE_SPACE : TONE_MARK;
  end

  assign tone_o = tone_q;

endmodule

// File: rtl/phase_accum.sv
module phase_accum
  import nrzi_tone_pkg::*;
#(
  parameter int               ACC_W     = 16,
  parameter logic [ACC_W-1:0] MARK_INC  = '0,
  parameter logic [ACC_W-1:0] SPACE_INC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  tone_e            tone_i,
  output logic [ACC_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_w;

  assign inc_w = (tone_i == TONE_SPACE) ? SPACE_INC : MARK_INC;

  // no reset on tone change: phase-continuous switch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!en_i)  acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + inc_w;
  end

  assign phase_o = acc_q;

endmodule

// File: rtl/nrzi_tone_synth.sv
module nrzi_tone_synth
  import nrzi_tone_pkg::*;
#(
  parameter int CLK_HZ    = 9_830_400,
  parameter int SAMPLE_HZ = 38_400,
  parameter int BAUD_HZ   = 1_200,
  parameter int MARK_HZ   = 1_200,
  parameter int SPACE_HZ  = 2_200,
  parameter int ACC_W     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       bit_i,
  output logic       bit_req_o,
  output logic [3:0] sample_o
);
  localparam int SAMPLE_DIV = CLK_HZ / SAMPLE_HZ;
  localparam int BAUD_DIV   = SAMPLE_HZ / BAUD_HZ;
  localparam longint unsigned ACC_SPAN = 64'd1 << ACC_W;
  localparam logic [ACC_W-1:0] MARK_INC  =
    ACC_W'((longint'(MARK_HZ) * ACC_SPAN) / longint'(SAMPLE_HZ));
  localparam logic [ACC_W-1:0] SPACE_INC =
    ACC_W'((longint'(SPACE_HZ) * ACC_SPAN) / longint'(SAMPLE_HZ));

  logic             tick_w;
  logic             baud_w;
  tone_e            tone_w;
  logic [ACC_W-1:0] phase_w;
  logic [3:0]       lut_w;

  tone_timebase #(
    .SAMPLE_DIV(SAMPLE_DIV),
    .BAUD_DIV  (BAUD_DIV)
  ) u_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_o(tick_w),
    .baud_o(baud_w)
  );

  nrzi_tone_select u_select (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .baud_i(baud_w),
    .bit_i (bit_i),
    .tone_o(tone_w)
  );

  phase_accum #(
    .ACC_W    (ACC_W),
    .MARK_INC (MARK_INC),
    .SPACE_INC(SPACE_INC)
  ) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_w),
    .tone_i (tone_w),
    .phase_o(phase_w)
  );

  assign lut_w     = sine16(phase_w[ACC_W-1 -: 4]);
  assign sample_o  = en_i ? lut_w : MIDSCALE;
  assign bit_req_o = baud_w;

endmodule

// File: rtl/nrzi_tone_synth_chk.sv
module nrzi_tone_synth_chk #(
  parameter int               ACC_W     = 16,
  parameter logic [ACC_W-1:0] MARK_INC  = '0,
  parameter logic [ACC_W-1:0] SPACE_INC = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             bit_i,
  input logic             bit_req_o,
  input logic             tick,
  input logic             tone,
  input logic [ACC_W-1:0] phase
);

  // R3
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o |=> !bit_req_o);

  // R8
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !bit_req_o);

  // R8
  idle_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase == '0) && !tone);

  // R4
  zero_bit_swaps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_req_o && !bit_i) |=> tone != $past(tone));

  // R9
  tone_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_req_o) |=> $stable(tone));

  // R2
  phase_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick) |=> $stable(phase));

  // R7
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ACC_W'(phase - $past(phase)) == ($past(tone) ? SPACE_INC : MARK_INC));

endmodule

bind nrzi_tone_synth nrzi_tone_synth_chk #(
  .ACC_W    (ACC_W),
  .MARK_INC (MARK_INC),
  .SPACE_INC(SPACE_INC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .bit_i    (bit_i),
  .bit_req_o(bit_req_o),
  .tick     (tick_w),
  .tone     (tone_w),
  .phase    (phase_w)
);

// File: tb/nrzi_tone_synth_bench.sv
module nrzi_tone_synth_bench;
  localparam int CLK_HZ    = 153_600;
  localparam int SAMPLE_HZ = 38_400;
  localparam int BAUD_HZ   = 1_200;
  localparam int ACC_W     = 16;
  localparam int SD  = CLK_HZ / SAMPLE_HZ;
  localparam int BD  = SAMPLE_HZ / BAUD_HZ;
  localparam int SYM = SD * BD;
  localparam int MI  = int'((longint'(1200) * 65536) / SAMPLE_HZ);
  localparam int SI  = int'((longint'(2200) * 65536) / SAMPLE_HZ);

  int table16 [16] = '{8,10,13,14,15,14,13,10,8,5,2,1,0,1,2,5};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       bit_in = 1'b0;
  logic       req;
  logic [3:0] smp;

  always #5 clk = ~clk;

  nrzi_tone_synth #(
    .CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .BAUD_HZ(BAUD_HZ),
    .MARK_HZ(1200), .SPACE_HZ(2200), .ACC_W(ACC_W)
  ) u_nrzi_tone_synth (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_i(bit_in),
    .bit_req_o(req), .sample_o(smp)
  );

  // behavioural reference
  int m_div, m_sym, m_acc, m_space;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_div = 0; m_sym = 0; m_acc = 0; m_space = 0;
    end else if (m_div == SD - 1) begin
      m_div = 0;
      m_acc = (m_acc + (m_space ? SI : MI)) % 65536;
      if (m_sym == BD - 1) begin
        m_sym = 0;
        if (bit_in == 1'b0) m_space = 1 - m_space;
      end else m_sym++;
    end else m_div++;
  end

  int    n_vec = 0, n_bad = 0, n_req = 0, cyc = 0;
  string tag = "R1";
  int    lfsr = 32'h1ACE;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic check(input string r, input int act, input int exp_v, input string what);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp_v);
    end
  endtask

  function automatic bit noise_bit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  // mode: 0 all ones, 1 all zeros, 2 alternating, 3 pseudo-random
  task automatic run(input string r, input bit e, input int cycles, input int mode);
    int k = 0;
    tag = r;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      en = e;
      #1;
      if (req) begin
        case (mode)
          0: bit_in = 1'b1;
          1: bit_in = 1'b0;
          2: bit_in = k[0];
          default: bit_in = noise_bit();
        endcase
        k++;
        n_req++;
      end else bit_in = noise_bit();
      #1;
      check(tag, req, (en && m_div == SD - 1 && m_sym == BD - 1) ? 1 : 0, "bit_req_o");
      check(tag, smp, en ? table16[m_acc >> (ACC_W - 4)] : 8, "sample_o");
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", req, 0, "bit_req_o in reset");
    check("R1", smp, 8, "sample_o in reset");
    rst_n = 1'b1;
    run("R1", 1'b0, 5, 0);
    // R5 start on mark, R9 noise between requests
    run("R5", 1'b1, 3 * SYM, 0);
    run("R9", 1'b1, 3 * SYM, 0);
    // R4 swaps on every zero, then alternating
    run("R4", 1'b1, 4 * SYM, 1);
    run("R4", 1'b1, 6 * SYM, 2);
    // R3 pulse count over an aligned window
    n_req = 0;
    run("R7", 1'b1, 10 * SYM, 3);
    check("R3", n_req, 10, "requests in ten symbol periods");
    // R8 disable mid-symbol, then R5 restart
    run("R2", 1'b1, 50, 3);
    run("R8", 1'b0, 20, 3);
    check("R8", smp, 8, "sample_o while disabled");
    check("R8", req, 0, "bit_req_o while disabled");
    run("R5", 1'b1, 2 * SYM, 1);
    run("R6", 1'b1, 4 * SYM, 3);
    run("R2", 1'b1, 2 * SYM, 2);
    summary();
  end

endmodule